// File: doc/BRIEF.md
# Six-Channel Memory/Peripheral DMA Engine

This block moves data between memory and peripheral FIFOs on behalf of up to six independent channels. Software programs each channel through a 32-bit register slave port. It sets a source address, a destination address, a count of transfer units and a command word that selects the unit size and which addresses advance. It then starts the channel by setting its enable and no-descriptor bits while the shared enable is on. A fixed address, with its increment bit clear, models a peripheral FIFO.

The engine issues one unit move at a time on a single memory port. The port carries the source address, the destination address and the unit-size code, and the move completes in any cycle where `mem_ack` is high while `mem_req` is high. When several channels are ready, a fixed-priority arbiter picks the lowest index. A channel whose addresses are not aligned to its unit size is stopped with error flags and moves nothing. When a count reaches zero the channel flags done and, if enabled, raises its bit in the shared interrupt status. The interrupt output stays high until software clears the done bit.

Top module: `dmac_top`

## Requirements
- R1: After reset every register reads 0, `mem_req` is 0 and `irq` is 0.
- R2: Channel n's bank starts at byte address n*0x20, with words at +0x00 (source), +0x04 (destination), +0x08 (unit count, 16 bits kept), +0x0C (request type, 5 bits kept), +0x10 (status, writable bits 31,6,4,3,2,1,0) and +0x14 (command, writable bits 23,22,15:12,10:8,7,1,0). +0x18 and the words at 0x308/0x30C read 0. Global control at 0x300 keeps bits 9:8, 3, 2 and 0.
- R3: A channel requests only while its status bit 0 (enable) and bit 31 (no-descriptor) are set, its bit 2 (halt), bit 3 (done) and bit 4 (address error) are clear, its count is nonzero, global bit 0 (enable) is set and global bit 3 (halt) is clear.
- R4: Each accepted move (`mem_req` and `mem_ack` high at a clock edge) lowers the granted channel's count by exactly one.
- R5: Command bits 10:8 give the unit size: code 0 is 4 bytes, 1 is 1 byte, 2 is 2 bytes, 3 is 16 bytes, 4 is 32 bytes, and other codes are 1 byte. After an accepted move the source advances by the unit size when command bit 23 is set, and the destination does so when bit 22 is set. Otherwise each stays unchanged.
- R6: Among ready channels the lowest index is granted, and at most one channel is granted at a time.
- R7: While `mem_req` is high and `mem_ack` low, with no register write, the request and its addresses and unit code hold in the next cycle.
- R8: A channel that is otherwise ready but whose source or destination is not a multiple of its unit size sets its status bits 4 and 2 and global bit 2, moves nothing, and keeps its count.
- R9: The accepted move that takes a count from 1 to 0 sets status bits 3 (done) and 1 (count ended), and the channel then stops.
- R10: Bit i of the read-only word at 0x304 is channel i's done bit AND its command bit 1. `irq` is the OR of those bits. A write to 0x304 has no effect, and clearing the done bit by a status write drops the bit.
- R11: Global bit 2 (address error), once set, stays set until a write to 0x300 changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | A unit move is requested |
| mem_src | output | 32 | Source address of the move |
| mem_dst | output | 32 | Destination address of the move |
| mem_unit | output | 3 | Unit-size code of the move |
| mem_ack | input | 1 | Move accepted and performed this cycle |
| irq | output | 1 | OR of the interrupt status bits |

## Verification
The assertions check on every cycle that at most one channel is granted, that no request appears while the shared enable is off or the shared halt is on, and that every issued move is aligned to its unit size. They also check that a stalled request holds steady, that the shared error flag is sticky, and that the interrupt changes only after a write or an accepted move. Only the bench scenarios can show the actual values: the counts and addresses left after a run for each unit size, the order in which competing channels are served, the status words after completion or an alignment fault, and the masking and clearing of the interrupt. The bench's reference model checks these against the outputs on every clock.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    // status word fields, most significant first
    typedef struct packed {
        logic nodesc;
        logic dinv;
        logic aerr;
        logic done;
        logic halt;
        logic cterm;
        logic en;
    } chan_stat_t;

    // command word fields
    typedef struct packed {
        logic       sinc;
        logic       dinc;
        logic [1:0] swid;
        logic [1:0] dwid;
        logic [2:0] unit;
        logic       blk;
        logic       tie;
        logic       link;
    } chan_cmd_t;

    typedef enum logic [2:0] {
        OFF_SRC  = 3'd0,
        OFF_DST  = 3'd1,
        OFF_CNT  = 3'd2,
        OFF_REQ  = 3'd3,
        OFF_STAT = 3'd4,
        OFF_CMD  = 3'd5
    } bank_off_e;

    function automatic logic [2:0] unit_shift(input logic [2:0] code);
        case (code)
            3'd0:    return 3'd2;
            3'd2:    return 3'd1;
            3'd3:    return 3'd4;
            3'd4:    return 3'd5;
            default: return 3'd0;
        endcase
    endfunction

    function automatic chan_stat_t stat_from_word(input logic [31:0] w);
        chan_stat_t s;
        s.nodesc = w[31];
        s.dinv   = w[6];
        s.aerr   = w[4];
        s.done   = w[3];
        s.halt   = w[2];
        s.cterm  = w[1];
        s.en     = w[0];
        return s;
    endfunction

    function automatic logic [31:0] stat_to_word(input chan_stat_t s);
        return {s.nodesc, 24'd0, s.dinv, 1'b0, s.aerr, s.done, s.halt, s.cterm, s.en};
    endfunction

    function automatic chan_cmd_t cmd_from_word(input logic [31:0] w);
        chan_cmd_t c;
        c.sinc = w[23];
        c.dinc = w[22];
        c.swid = w[15:14];
        c.dwid = w[13:12];
        c.unit = w[10:8];
        c.blk  = w[7];
        c.tie  = w[1];
        c.link = w[0];
        return c;
    endfunction

    function automatic logic [31:0] cmd_to_word(input chan_cmd_t c);
        return {8'd0, c.sinc, c.dinc, 6'd0, c.swid, c.dwid, 1'b0, c.unit,
                c.blk, 5'd0, c.tie, c.link};
    endfunction

endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_ok,
    input  logic          wr_en,
    input  logic [2:0]    wr_off,
    input  logic [31:0]   wdata,
    input  logic [2:0]    rd_off,
    output logic [31:0]   rdata,
    input  logic          grant,
    input  logic          ack,
    output logic          want,
    output logic          err_set,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [2:0]    unit,
    output logic          irq_bit
);
    logic [AW-1:0] src_q, dst_q;
    logic [CW-1:0] cnt_q;
    logic [RW-1:0] req_q;
    chan_stat_t    st_q;
    chan_cmd_t     cmd_q;

    logic [AW-1:0] step, amask;
    logic          misal, ready;

    always_comb begin
        step    = {{(AW-1){1'b0}}, 1'b1} << unit_shift(cmd_q.unit);
        amask   = step - 1'b1;
        misal   = |((src_q | dst_q) & amask);
        ready   = st_q.en & st_q.nodesc & ~st_q.halt & ~st_q.aerr & ~st_q.done
                  & (cnt_q != '0) & run_ok;
        want    = ready & ~misal;
        err_set = ready & misal;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
            req_q <= '0;
            st_q  <= '0;
            cmd_q <= '0;
        end else begin
            if (err_set) begin
                st_q.aerr <= 1'b1;
                st_q.halt <= 1'b1;
            end
            if (grant && ack) begin
                cnt_q <= cnt_q - 1'b1;
                if (cmd_q.sinc) src_q <= src_q + step;
                if (cmd_q.dinc) dst_q <= dst_q + step;
                if (cnt_q == CW'(1)) begin
                    st_q.done  <= 1'b1;
                    st_q.cterm <= 1'b1;
                end
            end
            if (wr_en) begin
                case (wr_off)
                    OFF_SRC:  src_q <= wdata[AW-1:0];
                    OFF_DST:  dst_q <= wdata[AW-1:0];
                    OFF_CNT:  cnt_q <= wdata[CW-1:0];
                    OFF_REQ:  req_q <= wdata[RW-1:0];
                    OFF_STAT: st_q  <= stat_from_word(wdata);
                    OFF_CMD:  cmd_q <= cmd_from_word(wdata);
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        case (rd_off)
            OFF_SRC:  rdata = 32'(src_q);
            OFF_DST:  rdata = 32'(dst_q);
            OFF_CNT:  rdata = 32'(cnt_q);
            OFF_REQ:  rdata = 32'(req_q);
            OFF_STAT: rdata = stat_to_word(st_q);
            OFF_CMD:  rdata = cmd_to_word(cmd_q);
            default:  rdata = '0;
        endcase
    end

    assign src     = src_q;
    assign dst     = dst_q;
    assign unit    = cmd_q.unit;
    assign irq_bit = st_q.done & cmd_q.tie;

endmodule

// File: rtl/dmac_arb.sv
module dmac_arb #(
    parameter int N = 6
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic taken;

    always_comb begin
        taken = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dmac_pkg::*;
#(
    parameter int NCH = 6,
    parameter int AW  = 32,
    parameter int CW  = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [9:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_src,
    output logic [AW-1:0] mem_dst,
    output logic [2:0]    mem_unit,
    input  logic          mem_ack,
    output logic          irq
);
    localparam int BANK_SPAN = NCH * 32;

    logic           in_bank, in_glob, word_ok;
    logic [2:0]     ch_sel, bank_off;
    logic [NCH-1:0] want, grant, err_set, irq_bits, wr_en;
    logic [AW-1:0]  ch_src [NCH];
    logic [AW-1:0]  ch_dst [NCH];
    logic [2:0]     ch_unit [NCH];
    logic [31:0]    ch_rdata [NCH];

    logic [1:0] g_pri;
    logic       g_halt, g_aerr, g_en, run_ok;

    assign word_ok  = (reg_addr[1:0] == 2'b00);
    assign in_bank  = word_ok && (32'(reg_addr) < BANK_SPAN);
    assign in_glob  = word_ok && (reg_addr[9:4] == 6'h30);
    assign ch_sel   = reg_addr[7:5];
    assign bank_off = reg_addr[4:2];
    assign run_ok   = g_en & ~g_halt;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign wr_en[i] = reg_we && in_bank && (ch_sel == 3'(i));
        dmac_chan #(.AW(AW), .CW(CW)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .run_ok  (run_ok),
            .wr_en   (wr_en[i]),
            .wr_off  (bank_off),
            .wdata   (reg_wdata),
            .rd_off  (bank_off),
            .rdata   (ch_rdata[i]),
            .grant   (grant[i]),
            .ack     (mem_ack),
            .want    (want[i]),
            .err_set (err_set[i]),
            .src     (ch_src[i]),
            .dst     (ch_dst[i]),
            .unit    (ch_unit[i]),
            .irq_bit (irq_bits[i])
        );
    end

    dmac_arb #(.N(NCH)) u_arb (
        .req   (want),
        .grant (grant)
    );

    always_comb begin
        mem_src  = '0;
        mem_dst  = '0;
        mem_unit = '0;
        for (int i = 0; i < NCH; i++) begin
            if (grant[i]) begin
                mem_src  = mem_src  | ch_src[i];
                mem_dst  = mem_dst  | ch_dst[i];
                mem_unit = mem_unit | ch_unit[i];
            end
        end
    end

    assign mem_req = |grant;
    assign irq     = |irq_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            g_pri  <= '0;
            g_halt <= 1'b0;
            g_aerr <= 1'b0;
            g_en   <= 1'b0;
        end else begin
            if (|err_set) g_aerr <= 1'b1;
            if (reg_we && in_glob && reg_addr[3:2] == 2'd0) begin
                g_pri  <= reg_wdata[9:8];
                g_halt <= reg_wdata[3];
                g_aerr <= reg_wdata[2];
                g_en   <= reg_wdata[0];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (in_bank) begin
            reg_rdata = ch_rdata[ch_sel];
        end else if (in_glob) begin
            case (reg_addr[3:2])
                2'd0:    reg_rdata = {22'd0, g_pri, 4'd0, g_halt, g_aerr, 1'b0, g_en};
                2'd1:    reg_rdata = 32'(irq_bits);
                default: reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dmac_chk.sv
module dmac_chk
    import dmac_pkg::*;
#(
    parameter int NCH = 6,
    parameter int AW  = 32
) (
    input logic           clk,
    input logic           rst,
    input logic           reg_we,
    input logic [9:0]     reg_addr,
    input logic           mem_req,
    input logic [AW-1:0]  mem_src,
    input logic [AW-1:0]  mem_dst,
    input logic [2:0]     mem_unit,
    input logic           mem_ack,
    input logic           irq,
    input logic [NCH-1:0] grant,
    input logic           g_en,
    input logic           g_halt,
    input logic           g_aerr
);
    logic [AW-1:0] umask;
    assign umask = ({{(AW-1){1'b0}}, 1'b1} << unit_shift(mem_unit)) - 1'b1;

    assert_one_grant_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_run_gate_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (g_en && !g_halt));

    assert_aligned_move_R8: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (((mem_src | mem_dst) & umask) == '0));

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !reg_we) |=>
        (mem_req && $stable(mem_src) && $stable(mem_dst) && $stable(mem_unit)));

    assert_gerr_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (g_aerr && !(reg_we && reg_addr == 10'h300)) |=> g_aerr);

    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (!reg_we && !(mem_req && mem_ack)) |=> $stable(irq));

endmodule

bind dmac_top dmac_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .mem_req  (mem_req),
    .mem_src  (mem_src),
    .mem_dst  (mem_dst),
    .mem_unit (mem_unit),
    .mem_ack  (mem_ack),
    .irq      (irq),
    .grant    (grant),
    .g_en     (g_en),
    .g_halt   (g_halt),
    .g_aerr   (g_aerr)
);

// File: tb/sim_dmac_top.sv
module sim_dmac_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_src, mem_dst;
    logic [2:0]  mem_unit;
    logic        mem_ack = 1'b0;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit cmp_on = 1'b0;

    always #5 clk = ~clk;

    dmac_top u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_src(mem_src), .mem_dst(mem_dst), .mem_unit(mem_unit),
        .mem_ack(mem_ack), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_src [6];
    logic [31:0] m_dst [6];
    logic [31:0] m_stat [6];
    logic [31:0] m_cmd [6];
    logic [15:0] m_cnt [6];
    logic [31:0] m_gctl;

    function automatic int m_bytes(input logic [2:0] code);
        case (code)
            3'd0: return 4;
            3'd2: return 2;
            3'd3: return 16;
            3'd4: return 32;
            default: return 1;
        endcase
    endfunction

    function automatic bit m_ready(input int c);
        return m_stat[c][0] && m_stat[c][31] && !m_stat[c][2] && !m_stat[c][3]
            && !m_stat[c][4] && m_cnt[c] != 0 && m_gctl[0] && !m_gctl[3];
    endfunction

    function automatic bit m_mis(input int c);
        int b;
        b = m_bytes(m_cmd[c][10:8]);
        return ((m_src[c] % b) != 0) || ((m_dst[c] % b) != 0);
    endfunction

    function automatic int m_pick();
        for (int c = 0; c < 6; c++)
            if (m_ready(c) && !m_mis(c)) return c;
        return -1;
    endfunction

    function automatic bit m_irq();
        for (int c = 0; c < 6; c++)
            if (m_stat[c][3] && m_cmd[c][1]) return 1'b1;
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 6; c++) begin
                m_src[c] = 0; m_dst[c] = 0; m_stat[c] = 0; m_cmd[c] = 0; m_cnt[c] = 0;
            end
            m_gctl = 0;
        end else begin
            int g;
            int b;
            g = m_pick();
            for (int c = 0; c < 6; c++) begin
                if (m_ready(c) && m_mis(c)) begin
                    m_stat[c] = m_stat[c] | 32'h14;
                    m_gctl[2] = 1'b1;
                end
            end
            if (g >= 0 && mem_ack) begin
                b = m_bytes(m_cmd[g][10:8]);
                if (m_cmd[g][23]) m_src[g] = m_src[g] + b;
                if (m_cmd[g][22]) m_dst[g] = m_dst[g] + b;
                if (m_cnt[g] == 1) m_stat[g] = m_stat[g] | 32'hA;
                m_cnt[g] = m_cnt[g] - 1;
            end
            if (reg_we) begin
                if (reg_addr < 10'h0C0 && reg_addr[1:0] == 0) begin
                    int c;
                    c = int'(reg_addr[7:5]);
                    case (reg_addr[4:2])
                        3'd0: m_src[c]  = reg_wdata;
                        3'd1: m_dst[c]  = reg_wdata;
                        3'd2: m_cnt[c]  = reg_wdata[15:0];
                        3'd4: m_stat[c] = reg_wdata & 32'h8000_005F;
                        3'd5: m_cmd[c]  = reg_wdata & 32'h00C0_F783;
                        default: ;
                    endcase
                end else if (reg_addr == 10'h300) begin
                    m_gctl = reg_wdata & 32'h30D;
                end
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            int g;
            g = m_pick();
            chk("R3 R6 cycle mem_req", 32'(mem_req), 32'(g >= 0));
            if (g >= 0) begin
                chk("R4 R5 R7 cycle mem_src", mem_src, m_src[g]);
                chk("R5 R7 cycle mem_dst", mem_dst, m_dst[g]);
                chk("R5 cycle mem_unit", 32'(mem_unit), 32'(m_cmd[g][10:8]));
            end
            chk("R10 cycle irq", 32'(irq), 32'(m_irq()));
        end
    end

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        cmp_on = 1'b1;
        // R1: reset values
        rd(10'h000, 0, "R1 src0");
        rd(10'h010, 0, "R1 stat0");
        rd(10'h300, 0, "R1 gctl");
        rd(10'h304, 0, "R1 irq status");
        chk("R1 irq pin", 32'(irq), 0);
        chk("R1 mem_req", 32'(mem_req), 0);

        // R2: map and writable fields, on channel 5
        wr(10'h0A0, 32'h1234_5678);
        wr(10'h0A8, 32'h0001_2345);
        wr(10'h0AC, 32'hFFFF_FFFF);
        wr(10'h0B4, 32'hFFFF_FFFF);
        wr(10'h0B0, 32'hFFFF_FFFF);
        wr(10'h0B8, 32'hFFFF_FFFF);
        rd(10'h0A0, 32'h1234_5678, "R2 src5");
        rd(10'h0A8, 32'h0000_2345, "R2 cnt5");
        rd(10'h0AC, 32'h0000_001F, "R2 req5");
        rd(10'h0B4, 32'h00C0_F783, "R2 cmd5");
        rd(10'h0B0, 32'h8000_005F, "R2 stat5");
        rd(10'h0B8, 0, "R2 desc5");
        wr(10'h308, 32'hFFFF_FFFF);
        rd(10'h308, 0, "R2 doorbell");
        wr(10'h0B0, 0);
        wr(10'h0B4, 0);

        // R3 R4 R5 R9 R10: channel 0, 4-byte units, source increments
        mem_ack = 1'b1;
        wr(10'h000, 32'h1000);
        wr(10'h004, 32'h2000);
        wr(10'h008, 3);
        wr(10'h014, 32'h0080_0002);
        wr(10'h010, 32'h8000_0001);
        idle(3);
        chk("R3 no request with global enable off", 32'(mem_req), 0);
        wr(10'h300, 1);
        idle(6);
        rd(10'h010, 32'h8000_000B, "R9 stat0 done");
        rd(10'h000, 32'h100C, "R5 src0 advanced");
        rd(10'h004, 32'h2000, "R5 dst0 fixed");
        rd(10'h008, 0, "R4 cnt0 zero");
        chk("R10 irq raised", 32'(irq), 1);
        rd(10'h304, 1, "R10 status bit0");
        wr(10'h304, 0);
        rd(10'h304, 1, "R10 status write ignored");
        wr(10'h010, 0);
        chk("R10 irq cleared", 32'(irq), 0);

        // R6 R7 R4: channel 1 (16 B) against channel 4 (4 B)
        mem_ack = 1'b0;
        wr(10'h020, 32'h4000); wr(10'h024, 32'h5000); wr(10'h028, 4);
        wr(10'h034, 32'h00C0_0300);
        wr(10'h080, 32'h8000); wr(10'h084, 32'h9000); wr(10'h088, 2);
        wr(10'h094, 32'h00C0_0000);
        wr(10'h090, 32'h8000_0001);
        idle(1);
        chk("R6 lone channel 4 served", mem_src, 32'h8000);
        wr(10'h030, 32'h8000_0001);
        idle(2);
        chk("R6 channel 1 wins", mem_src, 32'h4000);
        chk("R7 request held", 32'(mem_req), 1);
        mem_ack = 1'b1;
        idle(1);
        mem_ack = 1'b0;
        rd(10'h028, 3, "R4 cnt1 after one move");
        rd(10'h020, 32'h4010, "R5 src1 16-byte step");
        rd(10'h088, 2, "R6 cnt4 untouched");
        mem_ack = 1'b1;
        idle(10);
        rd(10'h024, 32'h5040, "R5 dst1 end");
        rd(10'h080, 32'h8008, "R5 src4 end");
        rd(10'h090, 32'h8000_000B, "R9 stat4 done");
        chk("R10 no irq without enable bit", 32'(irq), 0);
        wr(10'h030, 0);
        wr(10'h090, 0);

        // R5: 32-byte units and 1-byte units
        wr(10'h040, 32'h100); wr(10'h044, 32'h300); wr(10'h048, 2);
        wr(10'h054, 32'h0080_0400);
        wr(10'h050, 32'h8000_0001);
        idle(4);
        rd(10'h040, 32'h140, "R5 src2 32-byte step");
        rd(10'h044, 32'h300, "R5 dst2 fixed");
        wr(10'h060, 32'h7); wr(10'h064, 32'h9); wr(10'h068, 3);
        wr(10'h074, 32'h00C0_0100);
        wr(10'h070, 32'h8000_0001);
        idle(5);
        rd(10'h060, 32'hA, "R5 src3 byte step");
        rd(10'h064, 32'hC, "R5 dst3 byte step");

        // R8 R11: misaligned 2-byte channel
        wr(10'h050, 0);
        wr(10'h060, 32'h11); wr(10'h064, 32'h20); wr(10'h068, 5);
        wr(10'h074, 32'h00C0_0200);
        wr(10'h070, 32'h8000_0001);
        idle(3);
        rd(10'h070, 32'h8000_0015, "R8 stat3 error and halt");
        rd(10'h068, 5, "R8 cnt3 kept");
        rd(10'h300, 32'h5, "R11 global error set");
        idle(3);
        rd(10'h300, 32'h5, "R11 global error sticky");
        wr(10'h300, 1);
        rd(10'h300, 32'h1, "R11 global error cleared by write");
        wr(10'h070, 0);

        // R3: gating by no-descriptor bit and global halt
        wr(10'h000, 32'h1000); wr(10'h008, 2);
        wr(10'h014, 32'h0080_0000);
        wr(10'h010, 32'h0000_0001);
        idle(3);
        rd(10'h008, 2, "R3 no-descriptor bit clear blocks");
        wr(10'h300, 32'h9);
        wr(10'h010, 32'h8000_0001);
        idle(3);
        chk("R3 global halt blocks", 32'(mem_req), 0);
        rd(10'h008, 2, "R3 cnt0 held under halt");
        wr(10'h300, 1);
        idle(4);
        rd(10'h008, 0, "R3 runs after halt cleared");

        idle(2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule